// File: doc/BRIEF.md
# Two-Way Address Translation Unit with Block Override

This block turns a 32-bit effective address into a 32-bit physical address. The top four address bits choose one of sixteen segment registers, and that register yields a 24-bit virtual segment ID. The segment ID and the page-index bits form the tag for a 64-entry, two-way set-associative translation buffer. At the same time, a four-entry block-translation array compares the upper address bits against its programmed regions. When the block array hits, its result replaces any buffer result. Both structures enforce protection that depends on privilege level and on whether the access is a load or a store.

Software loads buffer entries through a fill port, removes single entries through an invalidate port, and programs the segment and block registers through write ports. A lookup that hits neither structure raises a one-cycle miss strobe. The faulting address, the access type and the privilege level are latched so that a software handler can read them. For each buffer entry the block tracks a referenced bit and a changed bit. The result of every lookup reports those bits as they stood before that access.

Top module: `xlat_unit`

## Requirements
- R1: After reset every segment register is zero, every buffer and block entry is invalid and all result and miss outputs are zero, so the first lookup misses.
- R2: A lookup presented at a clock edge produces its result, with res_valid high, after that same edge. res_valid is low after an edge with no lookup, and every result field except the latched miss context is then zero.
- R3: On a buffer hit, res_pa = {ppn, ea[11:0]}. The set is ea[16:12]. The tag is the segment ID from the segment register selected by ea[31:28], together with ea[27:17]. Two segments holding the same ID alias to the same entry, and a different ID misses.
- R4: Block entry i hits when (ea[31:17] & ~mask) == (epi & ~mask) and its valid bit for the current privilege is set (vs for supervisor, vu for user). The result is then res_pa = {(rpi & ~mask) | (ea[31:17] & mask), ea[16:0]} with res_bat=1. Where several entries hit, the lowest index wins.
- R5: When the block array and the buffer both hit, the block result is returned and the buffer entry's LRU, referenced and changed state are not updated.
- R6: A buffer entry with no_user set faults user accesses, and one with no_write set faults stores. A block entry with wp set faults stores. A faulting access still reports res_hit=1 and its physical address.
- R7: res_rc = {referenced, changed} of the hit buffer entry before the access. A fill clears both bits. A non-faulting buffer hit sets referenced, and a non-faulting store also sets changed. A faulting access changes neither. A block hit reports 2'b00.
- R8: A lookup that misses both structures gives res_hit=0 and a one-cycle miss_pulse. It also latches miss_ea, miss_store and miss_super, which hold their values until the next miss.
- R9: An invalidate clears only the entry in set inv_page[4:0] whose tag matches. A non-matching tag leaves the set unchanged, and the other way survives.
- R10: A fill writes way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the least recently used way. Every buffer hit and every fill makes the touched way most recent.
- R11: A fill or invalidate takes effect at the clock edge where it is presented. A lookup at that same edge sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 32 | Lookup effective address |
| lk_store | input | 1 | 1 = store, 0 = load |
| lk_super | input | 1 | 1 = supervisor, 0 = user |
| fill_valid | input | 1 | Buffer fill request |
| fill_page | input | 20 | Effective page number, ea[31:12], of the fill |
| fill_ppn | input | 20 | Physical page number to store |
| fill_no_user | input | 1 | Entry denies user access |
| fill_no_write | input | 1 | Entry denies stores |
| inv_valid | input | 1 | Invalidate request |
| inv_page | input | 20 | Effective page number to invalidate |
| seg_we | input | 1 | Segment register write |
| seg_idx | input | 4 | Segment register index |
| seg_vsid | input | 24 | Segment ID to write |
| bat_we | input | 1 | Block entry write |
| bat_idx | input | 2 | Block entry index |
| bat_epi | input | 15 | Block effective base, ea[31:17] |
| bat_rpi | input | 15 | Block physical base, pa[31:17] |
| bat_mask | input | 15 | Block length mask (ones pass address bits) |
| bat_vs | input | 1 | Valid for supervisor |
| bat_vu | input | 1 | Valid for user |
| bat_wp | input | 1 | Write-protect |
| res_valid | output | 1 | Result present |
| res_pa | output | 32 | Physical address |
| res_hit | output | 1 | Translation found |
| res_bat | output | 1 | Translation came from block array |
| res_fault | output | 1 | Protection fault |
| res_rc | output | 2 | {referenced, changed} before the access |
| miss_pulse | output | 1 | One-cycle miss strobe |
| miss_ea | output | 32 | Latched miss address |
| miss_store | output | 1 | Latched miss access type |
| miss_super | output | 1 | Latched miss privilege |

## Verification
Every result field and the miss strobe is registered once, so each appears one clock edge after its lookup. The bench drives each request on a falling edge and reads the outputs on the next falling edge, one half period after the capturing edge. Fills, invalidates and register writes update state at the edge where they are presented. Their effect is therefore checked with a lookup at a later edge, and a lookup placed at the same edge is checked to see the old contents.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
    localparam int EA_W   = 32;
    localparam int PAGE_W = 12;
    localparam int SEG_W  = 4;
    localparam int SET_W  = 5;
    localparam int VSID_W = 24;
    localparam int BLK_W  = 15;
    localparam int EPN_W  = EA_W - PAGE_W;
    localparam int PPN_W  = EA_W - PAGE_W;
    localparam int PIDX_W = EA_W - SEG_W - SET_W - PAGE_W;
    localparam int NSEG   = 1 << SEG_W;
    localparam int SETS   = 1 << SET_W;
    localparam int WAYS   = 2;
    localparam int OFFB_W = EA_W - BLK_W;

    typedef struct packed {
        logic [VSID_W-1:0] vsid;
        logic [PIDX_W-1:0] pidx;
    } tlb_tag_t;

    typedef struct packed {
        logic              valid;
        tlb_tag_t          tag;
        logic [PPN_W-1:0]  ppn;
        logic              no_user;
        logic              no_write;
        logic              ref_b;
        logic              chg_b;
    } tlb_entry_t;

    typedef struct packed {
        logic              vs;
        logic              vu;
        logic              wp;
        logic [BLK_W-1:0]  epi;
        logic [BLK_W-1:0]  rpi;
        logic [BLK_W-1:0]  mask;
    } bat_entry_t;
endpackage

// File: rtl/xlat_seg_file.sv
`timescale 1ns/1ps
module xlat_seg_file
    import xlat_pkg::*;
#(
    parameter int NRD = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [SEG_W-1:0]           widx,
    input  logic [VSID_W-1:0]          wvsid,
    input  logic [NRD-1:0][SEG_W-1:0]  rd_idx,
    output logic [NRD-1:0][VSID_W-1:0] rd_vsid
);
    logic [NSEG-1:0][VSID_W-1:0] seg_d, seg_q;

    always_comb begin
        seg_d = seg_q;
        if (we) begin
            seg_d[widx] = wvsid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= '0;
        end else begin
            seg_q <= seg_d;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_vsid[r] = seg_q[rd_idx[r]];
    end
endmodule

// File: rtl/xlat_bat_array.sv
`timescale 1ns/1ps
module xlat_bat_array
    import xlat_pkg::*;
#(
    parameter int NUM_BAT = 4,
    localparam int IDX_W  = (NUM_BAT > 1) ? $clog2(NUM_BAT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  bat_entry_t       wentry,
    input  logic [BLK_W-1:0] ea_hi,
    input  logic             super_mode,
    output logic             hit,
    output logic [BLK_W-1:0] pa_hi,
    output logic             wp
);
    bat_entry_t [NUM_BAT-1:0] bat_d, bat_q;
    logic [NUM_BAT-1:0]       match;

    always_comb begin
        bat_d = bat_q;
        if (we) begin
            bat_d[widx] = wentry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bat_q <= '0;
        end else begin
            bat_q <= bat_d;
        end
    end

    for (genvar i = 0; i < NUM_BAT; i++) begin : g_match
        assign match[i] = (super_mode ? bat_q[i].vs : bat_q[i].vu) &&
                          ((ea_hi & ~bat_q[i].mask) == (bat_q[i].epi & ~bat_q[i].mask));
    end

    always_comb begin
        hit   = 1'b0;
        pa_hi = '0;
        wp    = 1'b0;
        for (int i = NUM_BAT - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit   = 1'b1;
                pa_hi = (bat_q[i].rpi & ~bat_q[i].mask) | (ea_hi & bat_q[i].mask);
                wp    = bat_q[i].wp;
            end
        end
    end
endmodule

// File: rtl/xlat_tlb_array.sv
`timescale 1ns/1ps
module xlat_tlb_array
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [SET_W-1:0] lk_set,
    input  tlb_tag_t         lk_tag,
    input  logic             lk_store,
    input  logic             lk_super,
    input  logic             lk_bypass,
    input  logic             fill_valid,
    input  logic [SET_W-1:0] fill_set,
    input  tlb_tag_t         fill_tag,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_no_user,
    input  logic             fill_no_write,
    input  logic             inv_valid,
    input  logic [SET_W-1:0] inv_set,
    input  tlb_tag_t         inv_tag,
    output logic             hit,
    output logic [PPN_W-1:0] ppn,
    output logic             fault,
    output logic [1:0]       rc
);
    typedef struct packed {
        tlb_entry_t [SETS-1:0][WAYS-1:0] ent;
        logic       [SETS-1:0]           lru;
    } tlb_state_t;

    tlb_state_t      st_d, st_q;
    logic [WAYS-1:0] lk_match;
    logic            hit_way;
    tlb_entry_t      sel;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign lk_match[w] = st_q.ent[lk_set][w].valid &&
                             (st_q.ent[lk_set][w].tag == lk_tag);
    end

    assign hit     = |lk_match;
    assign hit_way = lk_match[1];
    assign sel     = st_q.ent[lk_set][hit_way];
    assign ppn     = sel.ppn;
    assign rc      = hit ? {sel.ref_b, sel.chg_b} : 2'b00;
    assign fault   = hit && ((sel.no_user && !lk_super) || (sel.no_write && lk_store));

    always_comb begin
        logic victim;
        st_d   = st_q;
        victim = 1'b0;

        if (lk_valid && hit && !lk_bypass) begin
            st_d.lru[lk_set] = ~hit_way;
            if (!fault) begin
                st_d.ent[lk_set][hit_way].ref_b = 1'b1;
                if (lk_store) begin
                    st_d.ent[lk_set][hit_way].chg_b = 1'b1;
                end
            end
        end

        if (inv_valid) begin
            for (int w = 0; w < WAYS; w++) begin
                if (st_q.ent[inv_set][w].valid && (st_q.ent[inv_set][w].tag == inv_tag)) begin
                    st_d.ent[inv_set][w].valid = 1'b0;
                end
            end
        end

        if (fill_valid) begin
            if (!st_d.ent[fill_set][0].valid) begin
                victim = 1'b0;
            end else if (!st_d.ent[fill_set][1].valid) begin
                victim = 1'b1;
            end else begin
                victim = st_d.lru[fill_set];
            end
            st_d.ent[fill_set][victim].valid    = 1'b1;
            st_d.ent[fill_set][victim].tag      = fill_tag;
            st_d.ent[fill_set][victim].ppn      = fill_ppn;
            st_d.ent[fill_set][victim].no_user  = fill_no_user;
            st_d.ent[fill_set][victim].no_write = fill_no_write;
            st_d.ent[fill_set][victim].ref_b    = 1'b0;
            st_d.ent[fill_set][victim].chg_b    = 1'b0;
            st_d.lru[fill_set]                  = ~victim;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/xlat_unit.sv
`timescale 1ns/1ps
module xlat_unit
    import xlat_pkg::*;
#(
    parameter int NUM_BAT = 4,
    localparam int BAT_IDX_W = (NUM_BAT > 1) ? $clog2(NUM_BAT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid,
    input  logic [EA_W-1:0]      lk_ea,
    input  logic                 lk_store,
    input  logic                 lk_super,
    input  logic                 fill_valid,
    input  logic [EPN_W-1:0]     fill_page,
    input  logic [PPN_W-1:0]     fill_ppn,
    input  logic                 fill_no_user,
    input  logic                 fill_no_write,
    input  logic                 inv_valid,
    input  logic [EPN_W-1:0]     inv_page,
    input  logic                 seg_we,
    input  logic [SEG_W-1:0]     seg_idx,
    input  logic [VSID_W-1:0]    seg_vsid,
    input  logic                 bat_we,
    input  logic [BAT_IDX_W-1:0] bat_idx,
    input  logic [BLK_W-1:0]     bat_epi,
    input  logic [BLK_W-1:0]     bat_rpi,
    input  logic [BLK_W-1:0]     bat_mask,
    input  logic                 bat_vs,
    input  logic                 bat_vu,
    input  logic                 bat_wp,
    output logic                 res_valid,
    output logic [EA_W-1:0]      res_pa,
    output logic                 res_hit,
    output logic                 res_bat,
    output logic                 res_fault,
    output logic [1:0]           res_rc,
    output logic                 miss_pulse,
    output logic [EA_W-1:0]      miss_ea,
    output logic                 miss_store,
    output logic                 miss_super
);
    localparam int NRD = 3;

    typedef struct packed {
        logic            valid;
        logic [EA_W-1:0] pa;
        logic            hit;
        logic            bat;
        logic            fault;
        logic [1:0]      rc;
        logic            miss;
        logic [EA_W-1:0] m_ea;
        logic            m_store;
        logic            m_super;
    } res_state_t;

    res_state_t r_d, r_q;

    logic [NRD-1:0][SEG_W-1:0]  seg_rd_idx;
    logic [NRD-1:0][VSID_W-1:0] seg_rd_vsid;
    tlb_tag_t                   lk_tag, fill_tag, inv_tag;
    bat_entry_t                 bat_wentry;
    logic                       bat_hit, bat_wp_hit;
    logic [BLK_W-1:0]           bat_pa_hi;
    logic                       tlb_hit, tlb_fault;
    logic [PPN_W-1:0]           tlb_ppn;
    logic [1:0]                 tlb_rc;

    assign seg_rd_idx[0] = lk_ea[EA_W-1 -: SEG_W];
    assign seg_rd_idx[1] = fill_page[EPN_W-1 -: SEG_W];
    assign seg_rd_idx[2] = inv_page[EPN_W-1 -: SEG_W];

    assign lk_tag   = {seg_rd_vsid[0], lk_ea[EA_W-SEG_W-1 -: PIDX_W]};
    assign fill_tag = {seg_rd_vsid[1], fill_page[EPN_W-SEG_W-1 -: PIDX_W]};
    assign inv_tag  = {seg_rd_vsid[2], inv_page[EPN_W-SEG_W-1 -: PIDX_W]};

    assign bat_wentry = '{vs: bat_vs, vu: bat_vu, wp: bat_wp,
                          epi: bat_epi, rpi: bat_rpi, mask: bat_mask};

    xlat_seg_file #(.NRD(NRD)) u_seg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (seg_we),
        .widx    (seg_idx),
        .wvsid   (seg_vsid),
        .rd_idx  (seg_rd_idx),
        .rd_vsid (seg_rd_vsid)
    );

    xlat_bat_array #(.NUM_BAT(NUM_BAT)) u_bat (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (bat_we),
        .widx       (bat_idx),
        .wentry     (bat_wentry),
        .ea_hi      (lk_ea[EA_W-1 -: BLK_W]),
        .super_mode (lk_super),
        .hit        (bat_hit),
        .pa_hi      (bat_pa_hi),
        .wp         (bat_wp_hit)
    );

    xlat_tlb_array u_tlb (
        .clk           (clk),
        .rst_n         (rst_n),
        .lk_valid      (lk_valid),
        .lk_set        (lk_ea[PAGE_W +: SET_W]),
        .lk_tag        (lk_tag),
        .lk_store      (lk_store),
        .lk_super      (lk_super),
        .lk_bypass     (bat_hit),
        .fill_valid    (fill_valid),
        .fill_set      (fill_page[SET_W-1:0]),
        .fill_tag      (fill_tag),
        .fill_ppn      (fill_ppn),
        .fill_no_user  (fill_no_user),
        .fill_no_write (fill_no_write),
        .inv_valid     (inv_valid),
        .inv_set       (inv_page[SET_W-1:0]),
        .inv_tag       (inv_tag),
        .hit           (tlb_hit),
        .ppn           (tlb_ppn),
        .fault         (tlb_fault),
        .rc            (tlb_rc)
    );

    always_comb begin
        r_d         = r_q;
        r_d.valid   = lk_valid;
        r_d.pa      = '0;
        r_d.hit     = 1'b0;
        r_d.bat     = 1'b0;
        r_d.fault   = 1'b0;
        r_d.rc      = 2'b00;
        r_d.miss    = 1'b0;
        if (lk_valid) begin
            if (bat_hit) begin
                r_d.pa    = {bat_pa_hi, lk_ea[OFFB_W-1:0]};
                r_d.hit   = 1'b1;
                r_d.bat   = 1'b1;
                r_d.fault = bat_wp_hit && lk_store;
            end else if (tlb_hit) begin
                r_d.pa    = {tlb_ppn, lk_ea[PAGE_W-1:0]};
                r_d.hit   = 1'b1;
                r_d.fault = tlb_fault;
                r_d.rc    = tlb_rc;
            end else begin
                r_d.miss    = 1'b1;
                r_d.m_ea    = lk_ea;
                r_d.m_store = lk_store;
                r_d.m_super = lk_super;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign res_valid  = r_q.valid;
    assign res_pa     = r_q.pa;
    assign res_hit    = r_q.hit;
    assign res_bat    = r_q.bat;
    assign res_fault  = r_q.fault;
    assign res_rc     = r_q.rc;
    assign miss_pulse = r_q.miss;
    assign miss_ea    = r_q.m_ea;
    assign miss_store = r_q.m_store;
    assign miss_super = r_q.m_super;
endmodule

// File: rtl/xlat_unit_chk.sv
`timescale 1ns/1ps
module xlat_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic [31:0] lk_ea,
    input logic        lk_store,
    input logic        lk_super,
    input logic        res_valid,
    input logic [31:0] res_pa,
    input logic        res_hit,
    input logic        res_bat,
    input logic        res_fault,
    input logic [1:0]  res_rc,
    input logic        miss_pulse,
    input logic [31:0] miss_ea,
    input logic        miss_store,
    input logic        miss_super
);
    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid); // R2

    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!res_valid && !res_hit && !miss_pulse)); // R2

    AST_PAGE_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!res_hit || res_pa[11:0] == $past(lk_ea[11:0]))); // R3

    AST_BAT_IMPLIES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        res_bat |-> res_hit); // R4

    AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> res_hit); // R6

    AST_BAT_NO_RC: assert property (@(posedge clk) disable iff (!rst_n)
        res_bat |-> (res_rc == 2'b00)); // R7

    AST_MISS_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        miss_pulse |-> (res_valid && !res_hit && !res_fault)); // R8

    AST_MISS_CONTEXT: assert property (@(posedge clk) disable iff (!rst_n)
        miss_pulse |-> (miss_ea == $past(lk_ea) && miss_store == $past(lk_store) &&
                        miss_super == $past(lk_super))); // R8

    AST_MISS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_pulse |-> ($stable(miss_ea) && $stable(miss_store) && $stable(miss_super))); // R8
endmodule

bind xlat_unit xlat_unit_chk u_chk (.*);

// File: tb/xlat_unit_bench.sv
`timescale 1ns/1ps
module xlat_unit_bench;
    localparam realtime CLK_P = 20.0;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, lk_store, lk_super;
    logic [31:0] lk_ea;
    logic        fill_valid, fill_no_user, fill_no_write;
    logic [19:0] fill_page, fill_ppn;
    logic        inv_valid;
    logic [19:0] inv_page;
    logic        seg_we;
    logic [3:0]  seg_idx;
    logic [23:0] seg_vsid;
    logic        bat_we, bat_vs, bat_vu, bat_wp;
    logic [1:0]  bat_idx;
    logic [14:0] bat_epi, bat_rpi, bat_mask;
    logic        res_valid, res_hit, res_bat, res_fault, miss_pulse, miss_store, miss_super;
    logic [31:0] res_pa, miss_ea;
    logic [1:0]  res_rc;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    xlat_unit u_xlat_unit (.*);

    // {ea, store, super, exp_hit, exp_bat, exp_fault, exp_pa}
    localparam int NV = 12;
    localparam logic [68:0] VECS [NV] = '{
        {32'h0000_5123, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'hAAAA_5123}, // R3 way0
        {32'h0000_5123, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0200_5123}, // R5 block wins
        {32'h0002_5ABC, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'hBBBB_1ABC}, // R3 way1
        {32'h0002_5ABC, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'hBBBB_1ABC}, // R6 user denied
        {32'h1000_7004, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 32'hCCCC_7004}, // R6 store denied
        {32'h1000_7004, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'hCCCC_7004}, // R6 load allowed
        {32'h2000_5010, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'hAAAA_5010}, // R3 alias
        {32'h3000_5010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0000}, // R3 other id
        {32'h4123_4567, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h1123_4567}, // R4 masked
        {32'h4123_4567, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'h1123_4567}, // R6 wp
        {32'h4123_4567, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000}, // R4 vu clear
        {32'h4200_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0000}  // R4 outside
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic idle_inputs();
        lk_valid = 0; lk_ea = '0; lk_store = 0; lk_super = 0;
        fill_valid = 0; fill_page = '0; fill_ppn = '0; fill_no_user = 0; fill_no_write = 0;
        inv_valid = 0; inv_page = '0;
        seg_we = 0; seg_idx = '0; seg_vsid = '0;
        bat_we = 0; bat_idx = '0; bat_epi = '0; bat_rpi = '0; bat_mask = '0;
        bat_vs = 0; bat_vu = 0; bat_wp = 0;
    endtask

    task automatic lookup(input logic [31:0] ea, input logic st, input logic su);
        lk_valid = 1; lk_ea = ea; lk_store = st; lk_super = su;
        @(negedge clk);
        lk_valid = 0;
    endtask

    task automatic set_fill(input logic [31:0] ea, input logic [19:0] ppn,
                            input logic nu, input logic nw);
        fill_valid = 1; fill_page = ea[31:12]; fill_ppn = ppn;
        fill_no_user = nu; fill_no_write = nw;
    endtask

    task automatic do_fill(input logic [31:0] ea, input logic [19:0] ppn,
                           input logic nu, input logic nw);
        set_fill(ea, ppn, nu, nw);
        @(negedge clk);
        fill_valid = 0;
    endtask

    task automatic do_inv(input logic [31:0] ea);
        inv_valid = 1; inv_page = ea[31:12];
        @(negedge clk);
        inv_valid = 0;
    endtask

    task automatic seg_wr(input logic [3:0] idx, input logic [23:0] v);
        seg_we = 1; seg_idx = idx; seg_vsid = v;
        @(negedge clk);
        seg_we = 0;
    endtask

    task automatic bat_wr(input logic [1:0] idx, input logic [14:0] epi, input logic [14:0] rpi,
                          input logic [14:0] msk, input logic vs, input logic vu, input logic wp);
        bat_we = 1; bat_idx = idx; bat_epi = epi; bat_rpi = rpi; bat_mask = msk;
        bat_vs = vs; bat_vu = vu; bat_wp = wp;
        @(negedge clk);
        bat_we = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired got=running exp=finished");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        chk("R1 res_valid", {31'd0, res_valid}, 32'd0);
        chk("R1 res_pa", res_pa, 32'd0);
        chk("R1 miss_ea", miss_ea, 32'd0);
        lookup(32'h0000_5123, 0, 1);
        chk("R1 first lookup hit", {31'd0, res_hit}, 32'd0);
        chk("R1 first lookup miss_pulse", {31'd0, miss_pulse}, 32'd1);

        // configuration
        seg_wr(4'd0, 24'h000100);
        seg_wr(4'd1, 24'h000200);
        seg_wr(4'd2, 24'h000100);
        seg_wr(4'd3, 24'h000300);
        bat_wr(2'd0, 15'h2000, 15'h0800, 15'h00FF, 1, 0, 1);
        bat_wr(2'd1, 15'h0000, 15'h0100, 15'h0000, 0, 1, 0);
        do_fill(32'h0000_5000, 20'hAAAA5, 0, 0);
        do_fill(32'h0002_5000, 20'hBBBB1, 1, 0);
        do_fill(32'h1000_7000, 20'hCCCC7, 0, 1);

        // R2 idle cycle output
        chk("R2 idle res_valid", {31'd0, res_valid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [68:0] v;
            v = VECS[i];
            lookup(v[68:37], v[36], v[35]);
            chk($sformatf("R2 vec%0d valid", i), {31'd0, res_valid}, 32'd1);
            chk($sformatf("R3/R4 vec%0d hit", i), {31'd0, res_hit}, {31'd0, v[34]});
            chk($sformatf("R5 vec%0d bat", i), {31'd0, res_bat}, {31'd0, v[33]});
            chk($sformatf("R6 vec%0d fault", i), {31'd0, res_fault}, {31'd0, v[32]});
            chk($sformatf("R3/R4 vec%0d pa", i), res_pa, v[31:0]);
            chk($sformatf("R8 vec%0d miss", i), {31'd0, miss_pulse}, {31'd0, ~v[34]});
        end

        // R7: faulting store left C clear, user load set R
        lookup(32'h1000_7004, 0, 1);
        chk("R7 rc after faulting store", {30'd0, res_rc}, 32'd2);
        do_fill(32'h1000_9000, 20'h12349, 0, 0);
        lookup(32'h1000_9010, 0, 1);
        chk("R7 rc fresh", {30'd0, res_rc}, 32'd0);
        lookup(32'h1000_9010, 0, 1);
        chk("R7 rc referenced", {30'd0, res_rc}, 32'd2);
        lookup(32'h1000_9010, 1, 1);
        chk("R7 rc before store", {30'd0, res_rc}, 32'd2);
        lookup(32'h1000_9010, 0, 1);
        chk("R7 rc changed", {30'd0, res_rc}, 32'd3);
        lookup(32'h0000_5000, 0, 0);
        chk("R7 bat rc", {30'd0, res_rc}, 32'd0);

        // R8: miss context latch and hold
        lookup(32'h3000_5010, 1, 0);
        chk("R8 miss pulse", {31'd0, miss_pulse}, 32'd1);
        chk("R8 miss_ea", miss_ea, 32'h3000_5010);
        chk("R8 miss_store", {31'd0, miss_store}, 32'd1);
        chk("R8 miss_super", {31'd0, miss_super}, 32'd0);
        lookup(32'h0000_5000, 0, 1);
        chk("R8 pulse drops", {31'd0, miss_pulse}, 32'd0);
        chk("R8 miss_ea held", miss_ea, 32'h3000_5010);

        // R11: fill at the same edge as lookup
        set_fill(32'h1000_B000, 20'h5555B, 0, 0);
        lookup(32'h1000_B000, 0, 1);
        fill_valid = 0;
        chk("R11 same-edge fill unseen", {31'd0, res_hit}, 32'd0);
        lookup(32'h1000_B000, 0, 1);
        chk("R11 fill visible later", res_pa, 32'h5555_B000);
        inv_valid = 1; inv_page = 20'h1000B;
        lookup(32'h1000_B000, 0, 1);
        inv_valid = 0;
        chk("R11 same-edge invalidate unseen", {31'd0, res_hit}, 32'd1);
        lookup(32'h1000_B000, 0, 1);
        chk("R11 invalidate visible later", {31'd0, res_hit}, 32'd0);

        // R9: selective invalidate
        do_inv(32'h3000_5000);
        lookup(32'h0000_5000, 0, 1);
        chk("R9 non-matching tag keeps way0", {31'd0, res_hit}, 32'd1);
        lookup(32'h0002_5000, 0, 1);
        chk("R9 non-matching tag keeps way1", {31'd0, res_hit}, 32'd1);
        do_inv(32'h0002_5000);
        lookup(32'h0002_5000, 0, 1);
        chk("R9 target removed", {31'd0, res_hit}, 32'd0);
        lookup(32'h0000_5000, 0, 1);
        chk("R9 other way survives", res_pa, 32'hAAAA_5000);

        // R10: replacement
        do_fill(32'h1000_C000, 20'h0000A, 0, 0);
        do_fill(32'h1002_C000, 20'h0000B, 0, 0);
        lookup(32'h1000_C000, 0, 1);
        do_fill(32'h1004_C000, 20'h0000C, 0, 0);
        lookup(32'h1002_C000, 0, 1);
        chk("R10 lru victim evicted", {31'd0, res_hit}, 32'd0);
        lookup(32'h1000_C000, 0, 1);
        chk("R10 recent way kept", res_pa, 32'h0000_A000);
        lookup(32'h1004_C000, 0, 1);
        chk("R10 new entry", res_pa, 32'h0000_C000);
        do_inv(32'h1004_C000);
        do_fill(32'h1006_C000, 20'h0000D, 0, 0);
        lookup(32'h1000_C000, 0, 1);
        chk("R10 invalid way filled first", res_pa, 32'h0000_A000);
        lookup(32'h1006_C000, 0, 1);
        chk("R10 filled entry", res_pa, 32'h0000_D000);

        finish_run();
    end
endmodule